// File: doc/BRIEF.md
# Bus-Based Register Datapath

This block is the execution core of a microcoded processor. It holds a small set of 32-bit registers, selects one of them onto a shared operand bus (the B bus), and combines that operand with a dedicated holding register in an ALU. An optional shifter follows the ALU. The result is driven onto a result bus (the C bus), and any group of registers can capture it in a single cycle. A microsequencer outside this block supplies the control fields for every cycle. A memory controller outside this block fills the byte buffer.

The ALU and the shifter are combinational and evaluate continuously. There is no strobe to start an operation. Control fields must settle after the falling clock edge. All registers that are selected for writing capture the C bus at the next rising edge, so a register that is read and written in the same cycle supplies its old value.

The registers are not all alike:

- The word address register can be written but is never driven onto the B bus.
- The holding register is always the left ALU operand and has no B-bus enable.
- The byte buffer cannot be written from the C bus. It has two B-bus enables: one zero-extends its byte and one sign-extends it.

Top module: `bus_datapath`

## Requirements
- R1: While rst_ni is low, every register (address, data, counter, holding, byte buffer, all general registers) reads zero.
- R2: The b_sel_i bits enable B-bus sources as follows: bit 0 is the data register, bit 1 is the counter, bit 2 is the byte buffer zero-extended, bit 3 is the byte buffer sign-extended, and bit 4+k is general register k. With one bit set, b_bus_o equals that source. With no bit set, b_bus_o is zero.
- R3: The zero-extend enable presents the byte buffer with bits 31:8 all clear. The sign-extend enable presents it with bits 31:8 equal to bit 7 of the byte buffer.
- R4: When more than one b_sel_i bit is set, bsel_err_o is high and b_bus_o is the bitwise OR of the selected sources. In that cycle no register is loaded from the C bus.
- R5: The left ALU operand is always the holding register, whatever b_sel_i selects.
- R6: alu_op_i codes: 0 returns H; 1 returns B; 2 returns H+B; 3 returns H AND B; 4 returns H OR B; 5 returns -H; 6 returns B+1; 7 returns B-H. All arithmetic is modulo 2^32.
- R7: n_o equals bit 31 of the ALU result, and z_o is high exactly when the ALU result is zero. Both flags are taken before the shifter.
- R8: shift_op_i codes: 0 and 3 pass the ALU result unchanged; 1 shifts it left logically by 8; 2 shifts it right arithmetically by 1. The outcome is c_bus_o.
- R9: c_mask_i bits select the registers that load c_bus_o at the rising edge: bit 0 is the address register, bit 1 the data register, bit 2 the counter, bit 3 the holding register, and bit 4+k general register k. Several bits may be set, and every selected register takes the same value. Unselected registers keep their value.
- R10: The address register never reaches b_bus_o. The byte buffer has no C-bus write path, so it changes only through mbuf_ld_i.
- R11: A register that is both the B source and a C destination in one cycle supplies its pre-edge value to the ALU. The new value appears after the rising edge.
- R12: When mbuf_ld_i is high, the byte buffer loads mbuf_din_i at the rising edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; registers load on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| b_sel_i | input | 9 | One-hot B-bus source enables |
| c_mask_i | input | 9 | C-bus write mask |
| alu_op_i | input | 3 | ALU function code |
| shift_op_i | input | 2 | Shifter control |
| mbuf_ld_i | input | 1 | Byte buffer load strobe from memory side |
| mbuf_din_i | input | 8 | Byte from memory side |
| b_bus_o | output | 32 | Current B-bus value |
| c_bus_o | output | 32 | Current C-bus value (after the shifter) |
| n_o | output | 1 | ALU result negative |
| z_o | output | 1 | ALU result zero |
| bsel_err_o | output | 1 | More than one B source enabled |
| addr_o | output | 32 | Word address register |
| wdat_o | output | 32 | Data register |
| pcnt_o | output | 32 | Counter register |
| hold_o | output | 32 | Holding register |
| mbuf_o | output | 8 | Byte buffer |
| gp_o | output | 160 | General registers, register k at bits 32k+31:32k |

## Verification
Three pairs of functions can fall in the same cycle:

- A register can be the B source and also be in the C write mask. The bench expects the ALU to see the old value and the register to take the new one only after the edge.
- An external byte load can coincide with a B-bus read of the byte buffer, in either extension. The read must return the previous byte.
- A multi-source B selection can coincide with a non-empty write mask. The bench expects the error flag and unchanged registers.

Directed cycles set up each of these collisions on purpose. A long stretch of mixed random cycles then provokes them at random, and every output is compared against a behavioural model on every clock.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef enum logic [2:0] {
    ALU_PASS_A = 3'd0,
    ALU_PASS_B = 3'd1,
    ALU_ADD    = 3'd2,
    ALU_AND    = 3'd3,
    ALU_OR     = 3'd4,
    ALU_NEG_A  = 3'd5,
    ALU_INC_B  = 3'd6,
    ALU_SUB    = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_SLL8 = 2'd1,
    SH_SRA1 = 2'd2,
    SH_RSVD = 2'd3
  } sh_op_e;

  // B-bus source positions
  localparam int BS_WDAT = 0;
  localparam int BS_PCNT = 1;
  localparam int BS_MBZX = 2;
  localparam int BS_MBSX = 3;
  localparam int BS_GP0  = 4;

  // C-bus write mask positions
  localparam int CW_ADDR = 0;
  localparam int CW_WDAT = 1;
  localparam int CW_PCNT = 2;
  localparam int CW_HOLD = 3;
  localparam int CW_GP0  = 4;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/dp_alu.sv
module dp_alu
  import bdp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [2:0]    op_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          z_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      ALU_PASS_A: res_o = a_i;
      ALU_PASS_B: res_o = b_i;
      ALU_ADD:    res_o = a_i + b_i;
      ALU_AND:    res_o = a_i & b_i;
      ALU_OR:     res_o = a_i | b_i;
      ALU_NEG_A:  res_o = '0 - a_i;
      ALU_INC_B:  res_o = b_i + DW'(1);
      ALU_SUB:    res_o = b_i - a_i;
      default:    res_o = '0;
    endcase
  end

  assign n_o = res_o[DW-1];
  assign z_o = (res_o == '0);
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
  import bdp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SHL_N = 8
) (
  input  logic [DW-1:0] d_i,
  input  logic [1:0]    op_i,
  output logic [DW-1:0] q_o
);
  sh_op_e op;
  assign op = sh_op_e'(op_i);

  always_comb begin
    unique case (op)
      SH_SLL8: q_o = {d_i[DW-SHL_N-1:0], {SHL_N{1'b0}}};
      SH_SRA1: q_o = {d_i[DW-1], d_i[DW-1:1]};
      default: q_o = d_i;
    endcase
  end
endmodule

// File: rtl/dp_bmux.sv
module dp_bmux
  import bdp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NUM_GP = 5,
  localparam int BS_W  = BS_GP0 + NUM_GP
) (
  input  logic [BS_W-1:0]      sel_i,
  input  logic [DW-1:0]        wdat_i,
  input  logic [DW-1:0]        pcnt_i,
  input  logic [BYTE_W-1:0]    mbuf_i,
  input  logic [NUM_GP*DW-1:0] gp_i,
  output logic [DW-1:0]        b_o,
  output logic                 err_o
);
  logic [DW-1:0] src [BS_W];

  assign src[BS_WDAT] = wdat_i;
  assign src[BS_PCNT] = pcnt_i;
  assign src[BS_MBZX] = {{(DW-BYTE_W){1'b0}}, mbuf_i};
  assign src[BS_MBSX] = {{(DW-BYTE_W){mbuf_i[BYTE_W-1]}}, mbuf_i};

  for (genvar k = 0; k < NUM_GP; k++) begin : g_src
    assign src[BS_GP0+k] = gp_i[k*DW +: DW];
  end

  // AND-OR bus: a conflict resolves to the OR of the drivers
  always_comb begin
    b_o = '0;
    for (int i = 0; i < BS_W; i++) begin
      if (sel_i[i]) b_o = b_o | src[i];
    end
  end

  assign err_o = ($countones(sel_i) > 1);
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
  import bdp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NUM_GP = 5,
  localparam int CW_W  = CW_GP0 + NUM_GP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW_W-1:0]      wr_mask_i,
  input  logic                 wr_en_i,
  input  logic [DW-1:0]        c_i,
  input  logic                 mbuf_ld_i,
  input  logic [BYTE_W-1:0]    mbuf_d_i,
  output logic [DW-1:0]        addr_o,
  output logic [DW-1:0]        wdat_o,
  output logic [DW-1:0]        pcnt_o,
  output logic [DW-1:0]        hold_o,
  output logic [BYTE_W-1:0]    mbuf_o,
  output logic [NUM_GP*DW-1:0] gp_o
);
  logic [CW_W-1:0] we;
  assign we = wr_en_i ? wr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      wdat_o <= '0;
      pcnt_o <= '0;
      hold_o <= '0;
    end else begin
      if (we[CW_ADDR]) addr_o <= c_i;
      if (we[CW_WDAT]) wdat_o <= c_i;
      if (we[CW_PCNT]) pcnt_o <= c_i;
      if (we[CW_HOLD]) hold_o <= c_i;
    end
  end

  // byte buffer: memory side only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mbuf_o <= '0;
    else if (mbuf_ld_i) mbuf_o <= mbuf_d_i;
  end

  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             gp_o[k*DW +: DW] <= '0;
      else if (we[CW_GP0+k])   gp_o[k*DW +: DW] <= c_i;
    end
  end

  // R12
  mbuf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mbuf_ld_i |=> $stable(mbuf_o));
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import bdp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NUM_GP = 5,
  localparam int BS_W  = BS_GP0 + NUM_GP,
  localparam int CW_W  = CW_GP0 + NUM_GP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BS_W-1:0]      b_sel_i,
  input  logic [CW_W-1:0]      c_mask_i,
  input  logic [2:0]           alu_op_i,
  input  logic [1:0]           shift_op_i,
  input  logic                 mbuf_ld_i,
  input  logic [BYTE_W-1:0]    mbuf_din_i,
  output logic [DW-1:0]        b_bus_o,
  output logic [DW-1:0]        c_bus_o,
  output logic                 n_o,
  output logic                 z_o,
  output logic                 bsel_err_o,
  output logic [DW-1:0]        addr_o,
  output logic [DW-1:0]        wdat_o,
  output logic [DW-1:0]        pcnt_o,
  output logic [DW-1:0]        hold_o,
  output logic [BYTE_W-1:0]    mbuf_o,
  output logic [NUM_GP*DW-1:0] gp_o
);
  logic [DW-1:0] alu_res;

  dp_bmux #(.DW(DW), .NUM_GP(NUM_GP)) u_bmux (
    .sel_i  (b_sel_i),
    .wdat_i (wdat_o),
    .pcnt_i (pcnt_o),
    .mbuf_i (mbuf_o),
    .gp_i   (gp_o),
    .b_o    (b_bus_o),
    .err_o  (bsel_err_o)
  );

  dp_alu #(.DW(DW)) u_alu (
    .a_i   (hold_o),
    .b_i   (b_bus_o),
    .op_i  (alu_op_i),
    .res_o (alu_res),
    .n_o   (n_o),
    .z_o   (z_o)
  );

  dp_shifter #(.DW(DW), .SHL_N(BYTE_W)) u_shift (
    .d_i  (alu_res),
    .op_i (shift_op_i),
    .q_o  (c_bus_o)
  );

  dp_regfile #(.DW(DW), .NUM_GP(NUM_GP)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mask_i (c_mask_i),
    .wr_en_i   (!bsel_err_o),
    .c_i       (c_bus_o),
    .mbuf_ld_i (mbuf_ld_i),
    .mbuf_d_i  (mbuf_din_i),
    .addr_o    (addr_o),
    .wdat_o    (wdat_o),
    .pcnt_o    (pcnt_o),
    .hold_o    (hold_o),
    .mbuf_o    (mbuf_o),
    .gp_o      (gp_o)
  );

  // R4
  no_write_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsel_err_o |=> ($stable(addr_o) && $stable(wdat_o) && $stable(pcnt_o)
                    && $stable(hold_o) && $stable(gp_o)));

  // R9
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_mask_i[CW_HOLD] && !bsel_err_o) |=> (hold_o == $past(c_bus_o)));

  // R3
  sign_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_sel_i == BS_W'(1 << BS_MBSX)) |-> (b_bus_o[DW-1:BYTE_W] == {(DW-BYTE_W){mbuf_o[BYTE_W-1]}}));

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_o && shift_op_i == SH_NONE) |-> (c_bus_o == '0));

  // R2
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_sel_i == '0) |-> (b_bus_o == '0));
endmodule

// File: tb/bus_datapath_test.sv
module bus_datapath_test;
  localparam int DW = 32;
  localparam int NG = 5;
  localparam int BW = 4 + NG;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [BW-1:0] b_sel = '0;
  logic [BW-1:0] c_mask = '0;
  logic [2:0]    alu_op = '0;
  logic [1:0]    sh_op = '0;
  logic          mb_ld = 1'b0;
  logic [7:0]    mb_din = '0;
  logic [31:0]   b_bus, c_bus, addr, wdat, pcnt, hold;
  logic          n_f, z_f, err;
  logic [7:0]    mbuf;
  logic [NG*32-1:0] gp;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_addr, m_wdat, m_pcnt, m_hold;
  logic [31:0] m_gp [NG];
  logic [7:0]  m_mbuf;

  always #5 clk = ~clk;

  bus_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .b_sel_i(b_sel), .c_mask_i(c_mask),
    .alu_op_i(alu_op), .shift_op_i(sh_op), .mbuf_ld_i(mb_ld), .mbuf_din_i(mb_din),
    .b_bus_o(b_bus), .c_bus_o(c_bus), .n_o(n_f), .z_o(z_f), .bsel_err_o(err),
    .addr_o(addr), .wdat_o(wdat), .pcnt_o(pcnt), .hold_o(hold), .mbuf_o(mbuf), .gp_o(gp)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk(req, "addr", addr, m_addr);
    chk(req, "wdat", wdat, m_wdat);
    chk(req, "pcnt", pcnt, m_pcnt);
    chk(req, "hold", hold, m_hold);
    chk(req, "mbuf", {24'd0, mbuf}, {24'd0, m_mbuf});
    for (int k = 0; k < NG; k++) chk(req, "gp", gp[k*32 +: 32], m_gp[k]);
  endtask

  function automatic logic [31:0] src_val(int i);
    case (i)
      0: return m_wdat;
      1: return m_pcnt;
      2: return {24'd0, m_mbuf};
      3: return {{24{m_mbuf[7]}}, m_mbuf};
      default: return m_gp[i-4];
    endcase
  endfunction

  // one datapath cycle: inputs applied after the falling edge
  task automatic cycle(logic [BW-1:0] bs, logic [BW-1:0] cm, int op, int sh,
                       logic ld, logic [7:0] din);
    logic [31:0] eb, ea, ec;
    int nsel;
    b_sel = bs; c_mask = cm; alu_op = 3'(op); sh_op = 2'(sh); mb_ld = ld; mb_din = din;
    #2;
    eb = '0; nsel = 0;
    for (int i = 0; i < BW; i++) if (bs[i]) begin eb |= src_val(i); nsel++; end
    case (op)
      0: ea = m_hold;
      1: ea = eb;
      2: ea = m_hold + eb;
      3: ea = m_hold & eb;
      4: ea = m_hold | eb;
      5: ea = 32'd0 - m_hold;
      6: ea = eb + 32'd1;
      default: ea = eb - m_hold;
    endcase
    case (sh)
      1: ec = ea << 8;
      2: ec = {ea[31], ea[31:1]};
      default: ec = ea;
    endcase
    chk("R2/R3/R4/R10", "b_bus", b_bus, eb);
    chk("R5/R6/R8/R11", "c_bus", c_bus, ec);
    chk("R7", "n", {31'd0, n_f}, {31'd0, ea[31]});
    chk("R7", "z", {31'd0, z_f}, {31'd0, ea == 32'd0});
    chk("R4", "err", {31'd0, err}, {31'd0, nsel > 1});
    @(posedge clk);
    if (nsel <= 1) begin
      if (cm[0]) m_addr = ec;
      if (cm[1]) m_wdat = ec;
      if (cm[2]) m_pcnt = ec;
      if (cm[3]) m_hold = ec;
      for (int k = 0; k < NG; k++) if (cm[4+k]) m_gp[k] = ec;
    end
    if (ld) m_mbuf = din;
    @(negedge clk);
    chk_regs("R9/R11/R12");
  endtask

  function automatic logic [BW-1:0] one(int i);
    return BW'(1) << i;
  endfunction

  initial begin
    m_addr = '0; m_wdat = '0; m_pcnt = '0; m_hold = '0; m_mbuf = '0;
    for (int k = 0; k < NG; k++) m_gp[k] = '0;
    repeat (3) @(negedge clk);
    chk_regs("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 byte load concurrent with sign-extended read of the old byte
    cycle(one(3), '0, 1, 0, 1'b1, 8'h85);
    // R3 sign extension of a negative byte into gp0 and hold
    cycle(one(3), one(4) | one(3), 1, 0, 1'b0, 8'h00);
    // R3 zero extension into gp1, R6 INC_B into counter
    cycle(one(2), one(5), 1, 0, 1'b0, 8'h00);
    cycle(one(2), one(2), 6, 0, 1'b0, 8'h00);
    // R11 counter read and written in one cycle
    cycle(one(1), one(1) | one(2), 6, 0, 1'b0, 8'h00);
    // R8 shifts
    cycle(one(4), one(6), 1, 1, 1'b0, 8'h00);
    cycle(one(4), one(7), 1, 2, 1'b0, 8'h00);
    // R9 multi-write incl. address register, R5 hold as left operand
    cycle(one(5), 9'b1_0000_0011, 2, 0, 1'b0, 8'h00);
    // R4 conflict with a full write mask
    cycle(one(4) | one(5), '1, 1, 0, 1'b0, 8'h00);
    // R2 no source; R7 zero result; R6 negate and subtract
    cycle('0, one(8), 1, 0, 1'b0, 8'h00);
    cycle('0, one(3), 5, 0, 1'b0, 8'h00);
    cycle(one(4), one(5), 7, 3, 1'b0, 8'h00);
    // mixed random cycles
    for (int t = 0; t < 3000; t++) begin
      logic [BW-1:0] bs;
      int r;
      r = int'($urandom % 8);
      if (r == 0) bs = '0;
      else if (r == 1) bs = one(int'($urandom % BW)) | one(int'($urandom % BW));
      else bs = one(int'($urandom % BW));
      cycle(bs, BW'($urandom), int'($urandom % 8), int'($urandom % 4),
            1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule